// File: doc/BRIEF.md
# SPI Command-Decoding Register Access Slave

This block sits behind a four-wire SPI port (mode 0: clock idles low, data sampled on the rising edge, changed on the falling edge). It gives an external master access to a 128-byte register file held in local flops. Every chip-select assertion starts with a one-byte command. The command picks one of these operations:
- a plain write or read with address auto-increment;
- a masked read-modify-write of one register;
- a reset of the whole register file;
- short-form commands that imply the start address of a transmit or receive message buffer;
- a request-to-send that marks transmit buffers as pending.

The serial pins are oversampled by the block's own clock through a synchronizer, so the SPI clock must be several times slower than the system clock. Each completed register write is echoed on a one-cycle strobe with its address and data, so a neighbouring protocol engine can track updates. A request-to-send raises a one-cycle pulse vector with one bit per transmit buffer.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, MISO is 0, no strobe or request pulse is raised, and every register is 0x00 except the control register at 0x0F, which holds 0x80. With chip select high, MISO stays 0.
- R2: Command 0x02, followed by an address byte, writes each following byte to consecutive addresses. Each write raises `wr_stb` for one cycle with its address and data.
- R3: Command 0x03, followed by an address byte, returns register contents MSB first on MISO. The data starts with the third byte of the transfer and continues at consecutive addresses.
- R4: Command 0x05 is followed by an address byte, a mask byte and a data byte. Only the register bits whose mask bit is 1 take the data bit. The merged value is written once and strobed.
- R5: Command 0xC0 returns every register to its R1 value, which puts the control register back to configuration mode (bits 7:5 = 100).
- R6: Commands 0x40, 0x42 and 0x44 select transmit buffer n = 0, 1 or 2 (n is command bits 2:1). Each writes its following bytes from address 0x31 + 0x10*n upward.
- R7: Commands 0x90 and 0x94 select receive buffer n = 0 or 1 (n is command bit 2). Each returns data on MISO from the second byte on, starting at address 0x61 + 0x10*n.
- R8: A command of the form 0x80 | m (m in bits 2:0) sets bit 3 of the buffer control register at 0x30 + 0x10*i for each set bit i of m. It also raises `rts_pulse` = m for one cycle when m is nonzero.
- R9: Raising chip select ends the command at once. An incomplete final byte has no effect, and the next transfer is decoded from a fresh command byte.
- R10: Any other command byte (for example 0x41, 0x46, 0x92 or 0xFF) changes no register, raises no strobe, and keeps MISO at 0 for the rest of the transfer.
- R11: During auto-increment, the address steps from 0x7F to 0x00.
- R12: Bytes sent after the data byte of a 0x05 command are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| wr_stb | output | 1 | One-cycle pulse per completed register write |
| wr_addr | output | 7 | Address of the strobed write |
| wr_data | output | 8 | Value written (the merged value for bit-modify) |
| rts_pulse | output | 3 | One-cycle transmit-request vector, bit i for buffer i |

## Verification
The bench targets the places where command framing is easy to get wrong. It reads back at 0x7F to catch an address counter that carries into an eighth bit instead of wrapping. It aborts mid-byte and mid-command: a design that commits partial bytes, or that resumes the old command after the abort, writes a stray register. It sends bytes after a bit-modify, and odd or out-of-range buffer commands: a design that keeps incrementing would corrupt neighbours, and a sloppy decoder would act on an unknown command. Short-form loads and reads check the implied start offset of one, and a reset command after a write to 0x0F checks that configuration mode is restored.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int DATA_W     = 8;
  localparam int TXB_BASE   = 'h30;
  localparam int RXB_BASE   = 'h60;
  localparam int BUF_STRIDE = 'h10;
  localparam int CTRL_ADDR  = 'h0F;
  localparam int TXREQ_BIT  = 3;
  localparam logic [DATA_W-1:0] CTRL_RST  = 8'h80;
  localparam logic [DATA_W-1:0] OP_WRITE  = 8'h02;
  localparam logic [DATA_W-1:0] OP_READ   = 8'h03;
  localparam logic [DATA_W-1:0] OP_BITMOD = 8'h05;
  localparam logic [DATA_W-1:0] OP_RESET  = 8'hC0;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_MASK, ST_BMDATA, ST_WRITE, ST_READ, ST_SKIP
  } cmd_state_e;

  typedef enum logic [1:0] {K_WRITE, K_READ, K_BITMOD} cmd_kind_e;
endpackage

// File: rtl/srs_pin_sync.sv
module srs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam logic [2:0] IDLE = 3'b010;  // {sck, cs_n, mosi}

  logic [2:0] chain [STAGES];
  logic       sck_prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [2:0] d;
    if (s == 0) begin : g_first
      assign d = {sck_i, cs_n_i, mosi_i};
    end else begin : g_next
      assign d = chain[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= IDLE;
      else        chain[s] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= chain[STAGES-1][2];
  end

  assign sck_rise = chain[STAGES-1][2] & ~sck_prev;
  assign sck_fall = ~chain[STAGES-1][2] & sck_prev;
  assign cs_act   = ~chain[STAGES-1][1];
  assign mosi_s   = chain[STAGES-1][0];
endmodule

// File: rtl/srs_shifter.sv
module srs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_act,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic         byte_done,
  output logic [W-1:0] byte_val,
  output logic         byte_start_fall,
  output logic         miso
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bit_q, bit_n;
  logic [W-1:0]  rx_q, rx_n, tx_q, tx_n;
  logic          en_q, en_n;

  always_comb begin
    bit_n = bit_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    en_n  = en_q;
    if (!cs_act) begin
      bit_n = '0;
      en_n  = 1'b0;
    end else if (sck_rise) begin
      rx_n  = {rx_q[W-2:0], mosi};
      bit_n = (bit_q == LAST) ? '0 : bit_q + 1'b1;
    end else if (sck_fall) begin
      if (bit_q == '0) begin
        if (load_en) begin
          tx_n = load_val;
          en_n = 1'b1;
        end
      end else begin
        tx_n = {tx_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      bit_q <= bit_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
      en_q  <= en_n;
    end
  end

  assign byte_done       = cs_act & sck_rise & (bit_q == LAST);
  assign byte_val        = {rx_q[W-2:0], mosi};
  assign byte_start_fall = cs_act & sck_fall & (bit_q == '0);
  assign miso            = en_q & tx_q[W-1];
endmodule

// File: rtl/srs_cmd_engine.sv
module srs_cmd_engine
  import srs_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_TXB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              byte_start_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              load_en,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              clr_all,
  output logic [NUM_TXB-1:0] rts_set
);
  localparam int HI_W = DATA_W - NUM_TXB;
  localparam logic [HI_W-1:0] RTS_HI = HI_W'(8'h80 >> NUM_TXB);

  cmd_state_e        st_q, st_n;
  cmd_kind_e         kind_q, kind_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] mask_q, mask_n;
  logic              is_load_tx, is_read_rx;

  assign is_load_tx = (byte_val[7:3] == 5'b01000) && !byte_val[0] &&
                      (int'(byte_val[2:1]) < NUM_TXB);
  assign is_read_rx = (byte_val[7:3] == 5'b10010) && (byte_val[1:0] == 2'b00);

  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    addr_n  = addr_q;
    mask_n  = mask_q;
    wr_en   = 1'b0;
    wr_data = byte_val;
    clr_all = 1'b0;
    rts_set = '0;
    load_en = 1'b0;
    if (!cs_act) begin
      st_n = ST_OP;
    end else if (byte_done) begin
      case (st_q)
        ST_OP: begin
          st_n = ST_SKIP;
          if (byte_val == OP_WRITE) begin
            kind_n = K_WRITE;
            st_n   = ST_ADDR;
          end else if (byte_val == OP_READ) begin
            kind_n = K_READ;
            st_n   = ST_ADDR;
          end else if (byte_val == OP_BITMOD) begin
            kind_n = K_BITMOD;
            st_n   = ST_ADDR;
          end else if (byte_val == OP_RESET) begin
            clr_all = 1'b1;
          end else if (is_load_tx) begin
            addr_n = ADDR_W'(TXB_BASE + BUF_STRIDE * int'(byte_val[2:1]) + 1);
            st_n   = ST_WRITE;
          end else if (is_read_rx) begin
            addr_n = ADDR_W'(RXB_BASE + BUF_STRIDE * int'(byte_val[2]) + 1);
            st_n   = ST_READ;
          end else if (byte_val[DATA_W-1:NUM_TXB] == RTS_HI) begin
            rts_set = byte_val[NUM_TXB-1:0];
          end
        end
        ST_ADDR: begin
          addr_n = byte_val[ADDR_W-1:0];
          case (kind_q)
            K_READ:   st_n = ST_READ;
            K_BITMOD: st_n = ST_MASK;
            default:  st_n = ST_WRITE;
          endcase
        end
        ST_MASK: begin
          mask_n = byte_val;
          st_n   = ST_BMDATA;
        end
        ST_BMDATA: begin
          wr_en   = 1'b1;
          wr_data = (rd_data & ~mask_q) | (byte_val & mask_q);
          st_n    = ST_SKIP;
        end
        ST_WRITE: begin
          wr_en  = 1'b1;
          addr_n = addr_q + 1'b1;
        end
        default: ;
      endcase
    end else if (byte_start_fall && (st_q == ST_READ)) begin
      load_en = 1'b1;
      addr_n  = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OP;
      kind_q <= K_WRITE;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      addr_q <= addr_n;
      mask_q <= mask_n;
    end
  end

  assign acc_addr = addr_q;
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile
  import srs_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_TXB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               clr_all,
  input  logic [NUM_TXB-1:0] rts_set,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_TXB-1:0] txreq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [DATA_W-1:0] RV = (g == CTRL_ADDR) ? CTRL_RST : '0;
    localparam bit IS_TXC = (g >= TXB_BASE) && (((g - TXB_BASE) % BUF_STRIDE) == 0) &&
                            (((g - TXB_BASE) / BUF_STRIDE) < NUM_TXB);
    localparam int TXI = IS_TXC ? (g - TXB_BASE) / BUF_STRIDE : 0;
    logic [DATA_W-1:0] q, d;
    logic              hit;
    assign hit = wr_en && (addr == ADDR_W'(g));

    if (IS_TXC) begin : g_ctl
      always_comb begin
        d = q;
        if (clr_all)           d = RV;
        else if (hit)          d = wr_data;
        else if (rts_set[TXI]) d[TXREQ_BIT] = 1'b1;
      end
      assign txreq[TXI] = q[TXREQ_BIT];
    end else begin : g_dat
      always_comb begin
        d = q;
        if (clr_all)  d = RV;
        else if (hit) d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RV;
      else        q <= d;
    end
    assign mem[g] = q;
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import srs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int NUM_TXB     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  output logic               wr_stb,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic [NUM_TXB-1:0] rts_pulse
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic sck_rise, sck_fall, cs_act, mosi_s;
  logic byte_done, byte_start_fall, load_en, wr_en, clr_all;
  logic [DATA_W-1:0]  byte_val, rd_data, wr_val;
  logic [ADDR_W-1:0]  acc_addr;
  logic [NUM_TXB-1:0] rts_set, txreq;

  srs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  srs_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi(mosi_s), .load_en(load_en), .load_val(rd_data),
    .byte_done(byte_done), .byte_val(byte_val), .byte_start_fall(byte_start_fall),
    .miso(miso)
  );

  srs_cmd_engine #(.ADDR_W(ADDR_W), .NUM_TXB(NUM_TXB)) u_cmd (
    .clk(clk), .rst_n(rst_core_n), .cs_act(cs_act), .byte_done(byte_done),
    .byte_val(byte_val), .byte_start_fall(byte_start_fall), .rd_data(rd_data),
    .acc_addr(acc_addr), .load_en(load_en), .wr_en(wr_en), .wr_data(wr_val),
    .clr_all(clr_all), .rts_set(rts_set)
  );

  srs_regfile #(.ADDR_W(ADDR_W), .NUM_TXB(NUM_TXB)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .addr(acc_addr), .wr_en(wr_en),
    .wr_data(wr_val), .clr_all(clr_all), .rts_set(rts_set),
    .rd_data(rd_data), .txreq(txreq)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rts_pulse <= '0;
    end else begin
      wr_stb    <= wr_en;
      rts_pulse <= rts_set;
      if (wr_en) begin
        wr_addr <= acc_addr;
        wr_data <= wr_val;
      end
    end
  end
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int NUM_TXB = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               miso,
  input logic               sck_fall,
  input logic               cs_act,
  input logic               byte_done,
  input logic               wr_stb,
  input logic [NUM_TXB-1:0] rts_pulse,
  input logic [NUM_TXB-1:0] txreq
);
  // R2: each write strobe follows a completed byte
  p_strobe_from_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(byte_done));

  // R3: MISO only moves after an SCK falling edge or when the select is released
  p_miso_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || !$past(cs_act)));

  // R8: a request pulse coincides with the pending bits being set
  p_rts_sets_txreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rts_pulse) |-> ((rts_pulse & txreq) == rts_pulse));

  // R8: the request vector is a single-cycle pulse
  p_rts_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rts_pulse) |=> (rts_pulse == '0));

  // R1: with chip select held high, MISO is 0
  p_idle_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !miso);
endmodule

bind spi_regfile_slave srs_checker #(.NUM_TXB(NUM_TXB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .sck_fall(sck_fall),
  .cs_act(cs_act), .byte_done(byte_done), .wr_stb(wr_stb),
  .rts_pulse(rts_pulse), .txreq(txreq)
);

// File: tb/spi_regfile_slave_test.sv
module spi_regfile_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic       miso, wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rts_pulse;

  int errors = 0;
  int checks = 0;
  logic [7:0]  mdl [128];
  logic [7:0]  txq [$];
  logic [14:0] exp_wr [$];
  logic [2:0]  exp_rts [$];

  always #4 clk = ~clk;

  spi_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rts_pulse(rts_pulse)
  );

  task automatic fail(input string req, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
  endtask

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) fail(req, what, act, expv);
  endtask

  // every-clock monitor of strobes and request pulses against the model's queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        checks++;
        if (exp_wr.size() == 0) fail("R2", "unexpected write strobe", {wr_addr, wr_data}, 0);
        else begin
          logic [14:0] e;
          e = exp_wr.pop_front();
          if ({wr_addr, wr_data} != e) fail("R2", "write strobe addr/data", {wr_addr, wr_data}, e);
        end
      end
      if (rts_pulse != 3'b000) begin
        checks++;
        if (exp_rts.size() == 0) fail("R8", "unexpected request pulse", rts_pulse, 0);
        else begin
          logic [2:0] r;
          r = exp_rts.pop_front();
          if (rts_pulse != r) fail("R8", "request pulse", rts_pulse, r);
        end
      end
    end
  end

  task automatic spi_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int k = 0; k < nbits; k++) begin
      mosi = b[7-k];
      repeat (8) @(negedge clk);
      got = {got[6:0], miso};
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // behavioural model of one transfer, then drive it and compare
  task automatic run(input string req, input int tail);
    int ph = 0;  // 0 cmd,1 addr,2 mask,3 bm data,4 write,5 read,6 ignore
    int kind = 0;
    int a = 0;
    logic [7:0] m = 8'h00;
    logic [7:0] expv [$];
    logic [7:0] got;
    for (int i = 0; i < txq.size(); i++) begin
      logic [7:0] b;
      b = txq[i];
      if (ph == 5) begin
        expv.push_back(mdl[a]);
        a = (a + 1) % 128;
      end else expv.push_back(8'h00);
      case (ph)
        0: begin
          ph = 6;
          if (b == 8'h02) begin kind = 0; ph = 1; end
          else if (b == 8'h03) begin kind = 1; ph = 1; end
          else if (b == 8'h05) begin kind = 2; ph = 1; end
          else if (b == 8'hC0) begin
            for (int r = 0; r < 128; r++) mdl[r] = 8'h00;
            mdl[15] = 8'h80;
          end else if (b == 8'h40 || b == 8'h42 || b == 8'h44) begin
            a = 'h31 + 16 * ((b >> 1) & 3); ph = 4;
          end else if (b == 8'h90 || b == 8'h94) begin
            a = (b == 8'h94) ? 'h71 : 'h61; ph = 5;
          end else if ((b & 8'hF8) == 8'h80) begin
            for (int t = 0; t < 3; t++) if (b[t]) mdl['h30 + 16 * t][3] = 1'b1;
            if (b[2:0] != 3'b000) exp_rts.push_back(b[2:0]);
          end
        end
        1: begin a = b[6:0]; ph = (kind == 1) ? 5 : (kind == 2) ? 2 : 4; end
        2: begin m = b; ph = 3; end
        3: begin
          mdl[a] = (mdl[a] & ~m) | (b & m);
          exp_wr.push_back({7'(a), mdl[a]});
          ph = 6;
        end
        4: begin
          mdl[a] = b;
          exp_wr.push_back({7'(a), b});
          a = (a + 1) % 128;
        end
        default: ;
      endcase
    end
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < txq.size(); i++) begin
      spi_bits(txq[i], 8, got);
      check(req, $sformatf("MISO byte %0d", i), got, expv[i]);
    end
    if (tail > 0) spi_bits(8'hFF, tail, got);
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
    check(req, "pending write strobes", exp_wr.size(), 0);
    check(req, "pending request pulses", exp_rts.size(), 0);
    check("R1", "MISO with select high", miso, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 128; r++) mdl[r] = 8'h00;
    mdl[15] = 8'h80;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1", "MISO after reset", miso, 0);
    check("R1", "wr_stb after reset", wr_stb, 0);
    check("R1", "rts_pulse after reset", rts_pulse, 0);

    // R1: reset contents, control register in configuration mode
    txq = {8'h03, 8'h0E, 8'h00, 8'h00, 8'h00}; run("R1", 0);
    // R2/R3: burst write, then burst read back
    txq = {8'h02, 8'h20, 8'hA1, 8'hB2, 8'hC3}; run("R2", 0);
    txq = {8'h03, 8'h1F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; run("R3", 0);
    // R4/R12: bit-modify with trailing bytes ignored
    txq = {8'h05, 8'h21, 8'hF0, 8'h5A, 8'hFF, 8'hFF}; run("R4", 0);
    txq = {8'h03, 8'h20, 8'h00, 8'h00, 8'h00}; run("R12", 0);
    // R6: short-form transmit buffer loads
    txq = {8'h42, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; run("R6", 0);
    txq = {8'h40, 8'h66, 8'h77}; run("R6", 0);
    txq = {8'h44, 8'h88}; run("R6", 0);
    txq = {8'h03, 8'h30, 8'h00, 8'h00, 8'h00}; run("R6", 0);
    txq = {8'h03, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; run("R6", 0);
    txq = {8'h03, 8'h50, 8'h00, 8'h00}; run("R6", 0);
    // R7: short-form receive buffer reads
    txq = {8'h02, 8'h61, 8'h9A, 8'h9B, 8'h9C}; run("R7", 0);
    txq = {8'h02, 8'h71, 8'hE1, 8'hE2}; run("R7", 0);
    txq = {8'h90, 8'h00, 8'h00, 8'h00, 8'h00}; run("R7", 0);
    txq = {8'h94, 8'h00, 8'h00, 8'h00}; run("R7", 0);
    // R8: request-to-send
    txq = {8'h85}; run("R8", 0);
    txq = {8'h82, 8'h00}; run("R8", 0);
    txq = {8'h80}; run("R8", 0);
    txq = {8'h03, 8'h30, 8'h00}; run("R8", 0);
    txq = {8'h03, 8'h40, 8'h00}; run("R8", 0);
    txq = {8'h03, 8'h50, 8'h00}; run("R8", 0);
    // R9: aborts mid-byte and mid-command, then fresh command
    txq = {8'h02, 8'h10}; run("R9", 5);
    txq = {}; run("R9", 4);
    txq = {8'h03, 8'h10, 8'h00, 8'h00}; run("R9", 0);
    txq = {8'h02, 8'h12, 8'h3C}; run("R9", 3);
    txq = {8'h03, 8'h12, 8'h00}; run("R9", 0);
    // R10: unrecognised commands
    txq = {8'h41, 8'h20, 8'hEE, 8'hEE}; run("R10", 0);
    txq = {8'h46, 8'h00, 8'hEE}; run("R10", 0);
    txq = {8'h92, 8'h00, 8'h00}; run("R10", 0);
    txq = {8'hFF, 8'h02, 8'h20, 8'h00}; run("R10", 0);
    txq = {8'h03, 8'h20, 8'h00, 8'h00, 8'h00}; run("R10", 0);
    // R11: address wrap on write and read
    txq = {8'h02, 8'h7E, 8'h11, 8'h22, 8'h33, 8'h44}; run("R11", 0);
    txq = {8'h03, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h00}; run("R11", 0);
    // R5: reset command restores configuration mode
    txq = {8'h02, 8'h0F, 8'h00}; run("R5", 0);
    txq = {8'hC0}; run("R5", 0);
    txq = {8'h03, 8'h0E, 8'h00, 8'h00, 8'h00}; run("R5", 0);
    txq = {8'h03, 8'h20, 8'h00, 8'h00}; run("R5", 0);
    txq = {8'h03, 8'h30, 8'h00}; run("R5", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule